// File: doc/BRIEF.md
# Multi-View Pixel Write Decoder

This block sits between a 32-bit bus write port and a pixel store. Each stored pixel holds three 8-bit colour channels and a 2-bit control field. The control field tells the display path how to show the pixel: 8-bit indexed, 24-bit indexed, 24-bit with gamma correction, or 24-bit raw. The same store can be written through three address windows. Each window has its own number of address bytes per pixel and its own rule for which pixel bits a write may change.

The upper address bits select the window and the lower bits give the offset inside it. In the red-only window there is one address byte per pixel, so a single 32-bit word covers four neighbouring pixels. The colour and raw windows use four address bytes per pixel and write one pixel per word. Only the raw window can write the control field. Writes that fall in any other window belong to other engines, and this block ignores them. A scan-out read port (`rd_idx`, `rd_pixel`) shows the stored pixels.

Top module: `mvfb_write_decoder`

## Requirements
- R1: After reset every pixel reads back as zero.
- R2: The window code is `wr_addr[ADDR_W-1:ADDR_W-WIN_W]`. Code 0 selects the red-only view, 1 the colour view and 2 the raw view. A write with any other code leaves every pixel unchanged.
- R3: A colour-view write updates pixel `offset>>2`, and offset bits [1:0] are ignored. Lane 0 (`wr_data[7:0]`) goes to blue, lane 1 to green and lane 2 to red. Lane 3 and the control field are left unchanged.
- R4: A raw-view write behaves like R3. In addition, when lane 3 is enabled, the control field is loaded from `wr_data[25:24]`. `wr_data[31:26]` is ignored.
- R5: A red-only-view write sends each enabled lane k (`wr_data[8k+7:8k]`) to the red channel of pixel `(offset & ~3) + k`. The lowest-addressed byte therefore reaches the lowest-numbered pixel. Green, blue and control are left unchanged.
- R6: A lane whose `wr_be` bit is 0 changes nothing. In the red-only view that lane's pixel keeps its red value. In the other views the matching channel keeps its value.
- R7: A red-only-view write whose offset is NPIX or more changes no pixel.
- R8: A write is visible on `rd_pixel` only after the clock edge that accepts it. In a cycle with `wr_valid` low, no pixel changes. Pixel format: [25:24] control, [23:16] red, [15:8] green, [7:0] blue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte address: window code and offset |
| wr_data | input | 32 | Write data, lane k in bits [8k+7:8k] |
| wr_be | input | 4 | Per-lane byte enables |
| rd_idx | input | IDX_W | Scan-out pixel index |
| rd_pixel | output | 26 | Stored pixel at `rd_idx` |

## Verification
The assertions assume that NPIX is a power of two of at least 4, so that colour and raw offsets can never leave the store. They also assume that `wr_valid`, `wr_addr`, `wr_data` and `wr_be` are steady around the clock edge. The stimulus drives every input on the falling edge and keeps the default NPIX. It also writes to out-of-range red-only offsets on purpose, to cover R7.

// File: rtl/mvfb_pkg.sv
package mvfb_pkg;
    typedef enum logic [1:0] {
        VIEW_NONE  = 2'd0,
        VIEW_R8    = 2'd1,
        VIEW_C24   = 2'd2,
        VIEW_RAW32 = 2'd3
    } view_e;

    typedef struct packed {
        logic [1:0] ctl;
        logic [7:0] red;
        logic [7:0] grn;
        logic [7:0] blu;
    } pix_t;

    localparam int WIN_CODE_R8  = 0;
    localparam int WIN_CODE_C24 = 1;
    localparam int WIN_CODE_RAW = 2;
    localparam int LANES        = 4;
endpackage

// File: rtl/mvfb_win_decode.sv
module mvfb_win_decode
    import mvfb_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int WIN_W = 3,
    localparam int ADDR_W = WIN_W + IDX_W + 2
) (
    input  logic [ADDR_W-1:0] addr,
    output view_e             view,
    output logic [IDX_W-1:0]  base_idx,
    output logic              in_range
);
    logic [WIN_W-1:0]   win;
    logic [IDX_W+1:0]   off;

    assign win = addr[ADDR_W-1:IDX_W+2];
    assign off = addr[IDX_W+1:0];

    always_comb begin
        view     = VIEW_NONE;
        base_idx = off[IDX_W+1:2];
        in_range = 1'b1;
        if (win == WIN_W'(WIN_CODE_R8)) begin
            view     = VIEW_R8;
            base_idx = {off[IDX_W-1:2], 2'b00};
            in_range = (off[IDX_W+1:IDX_W] == 2'b00);
        end else if (win == WIN_W'(WIN_CODE_C24)) begin
            view = VIEW_C24;
        end else if (win == WIN_W'(WIN_CODE_RAW)) begin
            view = VIEW_RAW32;
        end
    end
endmodule

// File: rtl/mvfb_lane_merge.sv
module mvfb_lane_merge
    import mvfb_pkg::*;
#(
    parameter int LANE = 0
) (
    input  view_e       view,
    input  pix_t        old_pix,
    input  logic [31:0] data,
    input  logic [3:0]  be,
    output logic        en,
    output pix_t        new_pix
);
    logic unused_hi;
    assign unused_hi = ^data[31:26];

    always_comb begin
        new_pix = old_pix;
        en      = 1'b0;
        if (view == VIEW_R8) begin
            en = be[LANE];
            if (be[LANE]) new_pix.red = data[8*LANE +: 8];
        end else if (LANE == 0 && (view == VIEW_C24 || view == VIEW_RAW32)) begin
            en = (|be[2:0]) || (view == VIEW_RAW32 && be[3]);
            if (be[0]) new_pix.blu = data[7:0];
            if (be[1]) new_pix.grn = data[15:8];
            if (be[2]) new_pix.red = data[23:16];
            if (view == VIEW_RAW32 && be[3]) new_pix.ctl = data[25:24];
        end
    end
endmodule

// File: rtl/mvfb_write_decoder.sv
module mvfb_write_decoder
    import mvfb_pkg::*;
#(
    parameter int NPIX  = 64,
    parameter int WIN_W = 3,
    localparam int IDX_W  = $clog2(NPIX),
    localparam int ADDR_W = WIN_W + IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [3:0]        wr_be,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [25:0]       rd_pixel
);
    typedef struct packed {
        pix_t [NPIX-1:0] pix;
    } state_t;

    state_t st_d, st_q;

    view_e            dec_view;
    view_e            view_g;
    logic [IDX_W-1:0] dec_base;
    logic             dec_in_range;

    logic [LANES-1:0] ch_en;
    logic [IDX_W-1:0] ch_idx [LANES];
    pix_t             ch_old [LANES];
    pix_t             ch_new [LANES];

    mvfb_win_decode #(.IDX_W(IDX_W), .WIN_W(WIN_W)) u_dec (
        .addr     (wr_addr),
        .view     (dec_view),
        .base_idx (dec_base),
        .in_range (dec_in_range)
    );

    assign view_g = (wr_valid && dec_in_range) ? dec_view : VIEW_NONE;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign ch_idx[k] = (dec_view == VIEW_R8) ? (dec_base | IDX_W'(k)) : dec_base;
        assign ch_old[k] = st_q.pix[ch_idx[k]];

        mvfb_lane_merge #(.LANE(k)) u_merge (
            .view    (view_g),
            .old_pix (ch_old[k]),
            .data    (wr_data),
            .be      (wr_be),
            .en      (ch_en[k]),
            .new_pix (ch_new[k])
        );

        // R5: non-raw writes never alter the control field
        assert_nonraw_ctl_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[k] && view_g != VIEW_RAW32) |-> ch_new[k].ctl == ch_old[k].ctl);
        // R5: red-only view keeps green and blue
        assert_r8_keep_gb_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[k] && view_g == VIEW_R8) |->
            (ch_new[k].grn == ch_old[k].grn && ch_new[k].blu == ch_old[k].blu));
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < LANES; k++) begin
            if (ch_en[k]) st_d.pix[ch_idx[k]] = ch_new[k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_pixel = st_q.pix[rd_idx];

    // R3: wide views touch a single pixel
    assert_wide_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (view_g == VIEW_C24 || view_g == VIEW_RAW32) |-> ch_en[3:1] == 3'b000);
    // R2: foreign windows leave the store alone
    assert_foreign_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && dec_view == VIEW_NONE) |=> st_q == $past(st_q));
    // R7: out-of-range red-only offsets enable nothing
    assert_range_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !dec_in_range) |-> ch_en == '0);
    // R8: idle cycles hold the store
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> st_q == $past(st_q));
endmodule

// File: tb/sim_mvfb_write_decoder.sv
`timescale 1ns/1ps
module sim_mvfb_write_decoder;
    localparam int NPIX = 64;
    localparam int IDX_W = 6;
    localparam int ADDR_W = 3 + IDX_W + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [3:0]        wr_be = '0;
    logic [IDX_W-1:0]  rd_idx = '0;
    logic [25:0]       rd_pixel;

    int n_cmp = 0;
    int n_bad = 0;
    logic [25:0] exp_pix [NPIX];

    always #4 clk = ~clk;

    mvfb_write_decoder #(.NPIX(NPIX), .WIN_W(3)) u0 (
        .clk, .rst_n, .wr_valid, .wr_addr, .wr_data, .wr_be, .rd_idx, .rd_pixel
    );

    task automatic cmp(input logic [25:0] act, input logic [25:0] exp, input string tag, input int idx);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s pixel %0d: actual %h expected %h", tag, idx, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        for (int i = 0; i < NPIX; i++) begin
            rd_idx = IDX_W'(i);
            #0.05;
            cmp(rd_pixel, exp_pix[i], tag, i);
        end
    endtask

    task automatic model(input int win, input logic [7:0] off, input logic [31:0] d, input logic [3:0] be);
        int p;
        if (win == 0) begin
            if (off[7:6] == 2'b00)
                for (int k = 0; k < 4; k++)
                    if (be[k]) exp_pix[{off[5:2], 2'(k)}][23:16] = d[8*k +: 8];
        end else if (win == 1 || win == 2) begin
            p = int'(off[7:2]);
            if (be[0]) exp_pix[p][7:0]   = d[7:0];
            if (be[1]) exp_pix[p][15:8]  = d[15:8];
            if (be[2]) exp_pix[p][23:16] = d[23:16];
            if (win == 2 && be[3]) exp_pix[p][25:24] = d[25:24];
        end
    endtask

    task automatic wr(input int win, input logic [7:0] off, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = {3'(win), off};
        wr_data  = d;
        wr_be    = be;
        @(negedge clk);
        wr_valid = 1'b0;
        model(win, off, d, be);
    endtask

    task automatic t_reset;
        for (int i = 0; i < NPIX; i++) exp_pix[i] = '0;
        chk_all("R1");
    endtask

    task automatic t_color;
        wr(1, 8'h14, 32'hAB112233, 4'hF);
        wr(1, 8'h1B, 32'h00445566, 4'hF);
        chk_all("R3");
    endtask

    task automatic t_raw;
        wr(2, 8'h1C, 32'hFEABCDEF, 4'hF);
        chk_all("R4");
        wr(1, 8'h1C, 32'hFF010203, 4'hF);
        chk_all("R3");
    endtask

    task automatic t_red_byte;
        wr(2, 8'h74, 32'h03102030, 4'hF);
        wr(0, 8'h1D, 32'h00007700, 4'b0010);
        chk_all("R5");
    endtask

    task automatic t_red_word;
        wr(0, 8'h08, 32'h44332211, 4'hF);
        chk_all("R5");
    endtask

    task automatic t_byte_en;
        wr(1, 8'h14, 32'h00EEFFCC, 4'b0101);
        wr(0, 8'h08, 32'h99887766, 4'b1010);
        wr(2, 8'h1C, 32'h01000000, 4'b0000);
        chk_all("R6");
    endtask

    task automatic t_foreign;
        wr(3, 8'h14, 32'hFFFFFFFF, 4'hF);
        wr(5, 8'h08, 32'h12345678, 4'hF);
        wr(7, 8'h00, 32'hFFFFFFFF, 4'hF);
        chk_all("R2");
    endtask

    task automatic t_range;
        wr(0, 8'h44, 32'hDEADBEEF, 4'hF);
        wr(0, 8'hC8, 32'hCAFEF00D, 4'hF);
        chk_all("R7");
    endtask

    task automatic t_timing;
        @(negedge clk);
        rd_idx   = IDX_W'(40);
        wr_valid = 1'b1;
        wr_addr  = {3'd1, 8'hA0};
        wr_data  = 32'h00A1B2C3;
        wr_be    = 4'hF;
        #1;
        cmp(rd_pixel, exp_pix[40], "R8", 40);
        @(negedge clk);
        wr_valid = 1'b0;
        model(1, 8'hA0, 32'h00A1B2C3, 4'hF);
        cmp(rd_pixel, exp_pix[40], "R8", 40);
        wr_addr = {3'd2, 8'h20};
        wr_data = 32'hFFFFFFFF;
        repeat (3) @(negedge clk);
        chk_all("R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_color;
        t_raw;
        t_red_byte;
        t_red_word;
        t_byte_en;
        t_foreign;
        t_range;
        t_timing;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8.0 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule